// File: doc/BRIEF.md
# Multi-Channel Divider Output Synchronizer

This block holds a bank of programmable clock dividers that all run from one channel input clock. Each channel divides that clock by a programmed ratio and can start late by a programmed number of input cycles, so that its output edges line up with, or sit a fixed distance from, the edges of its neighbours. A synchronization event freezes every channel that takes part at a static low level. When the event ends, all of those channels restart together after a fixed latency, each from its own start delay.

Several sources can request synchronization, and they are OR-ed into one internal request. The sources are an active-low sync pin, an active-low power-down pin, a calibration-busy input, three control bits written through the register port, and the power-up that follows block reset. Register writes land in shadow copies and only reach the active copies on an update strobe. A channel that carries the exclude flag ignores every sync event and keeps running with the settings it was last started with.

Top module: `mcs_divsync`

## Requirements
- R1: A write stores `wr_data` into a shadow copy only; the active copy takes the shadow value on the cycle `upd_all` is high. A channel word at address i (i < NCH) holds the ratio code in bits [DW-1:0], the start delay in bits [DW+PW-1:DW] and the exclude flag in bit DW+PW. The control word at address NCH holds soft sync in bit 0, soft reset in bit 1 and distribution power-down in bit 2.
- R2: A running channel with ratio code c has a period of c+2 input cycles. Its output is high for the first floor((c+2)/2) cycles of each period, counted from a rising edge.
- R3: While the combined request is active, every channel without the exclude flag drives its output low.
- R4: If `sync_n` is first sampled high at edge n after a low pulse, a channel with start delay 0 goes high right after edge n+14, which is 14 to 15 cycles after the pin rose.
- R5: A channel with start delay p has its first rising edge p cycles after a delay-0 channel. Channels with equal delays rise on the same edge.
- R6: A channel whose active exclude flag is set is neither held nor restarted by any sync event, and its output pattern continues unchanged.
- R7: Setting any of the three control bits through an update holds the channels. Clearing the bits with an update sampled at edge u releases them, and delay-0 channels go high right after edge u+13.
- R8: `pdn_n` acts exactly like `sync_n`, including the release latency of R4.
- R9: `cal_busy` high holds the channels. If it is first sampled low at edge n, delay-0 channels go high right after edge n+12.
- R10: While `rst_n` is low all outputs are low. If `rst_n` is released before edge 1, all channels start with code 0 (ratio 2), delay 0 and no exclusion, and go high right after edge 13.
- R11: Ratio code and start delay are captured while a channel is held. Updates made while a channel runs do not change its output until the next release.
- R12: When sources overlap, release is timed from the last source to deassert. Removing one source while another is still active releases nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel input clock |
| rst_n | input | 1 | Active-low block reset; its release starts the power-up sync |
| sync_n | input | 1 | Asynchronous active-low manual sync pin |
| pdn_n | input | 1 | Asynchronous active-low power-down pin, a sync source |
| cal_busy | input | 1 | High for the length of a calibration, a sync source |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | AW | Register address: channel words 0..NCH-1, control word NCH |
| wr_data | input | WW | Register write data |
| upd_all | input | 1 | Copies every shadow register into its active register |
| clk_out | output | NCH | Divided channel outputs |

## Verification
The bench goes after the release edge itself. It predicts every output from its own period and start-delay model, so a release that is one cycle early or late, or a delay that is off by one, shows up on the first edge. Excluded channels are compared on every cycle across each kind of sync event. A design that reset them would stall or shift their pattern, and the bench would report it. Overlapping calibration and pin requests check that release waits for the last source; a design that released on the first deassertion would start the outputs too early. Shadow writes without a strobe, and strobed writes while channels run, check that nothing moves before the next release. A design that passed the registers through live would change the period at once.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int unsigned CTRL_W        = 3;
  localparam int unsigned CTRL_SOFT_SYNC = 0;
  localparam int unsigned CTRL_SOFT_RST  = 1;
  localparam int unsigned CTRL_DIST_PD   = 2;

  // period of a channel in input cycles for a given ratio code
  function automatic int unsigned div_ratio(input int unsigned code);
    return code + 2;
  endfunction

  // number of high cycles at the start of each period
  function automatic int unsigned high_len(input int unsigned code);
    return div_ratio(code) / 2;
  endfunction
endpackage

// File: rtl/mcs_sync_ff.sv
module mcs_sync_ff #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/mcs_regfile.sv
module mcs_regfile #(
  parameter int NCH = 4,
  parameter int DW  = 4,
  parameter int PW  = 4,
  parameter int AW  = 3,
  parameter int WW  = DW + PW + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [WW-1:0]                 wr_data,
  input  logic                          upd_all,
  output logic [NCH-1:0][DW-1:0]        act_div,
  output logic [NCH-1:0][PW-1:0]        act_ph,
  output logic [NCH-1:0]                act_ex,
  output logic [mcs_pkg::CTRL_W-1:0]    act_ctrl
);
  localparam int CW = mcs_pkg::CTRL_W;

  for (genvar g = 0; g < NCH; g++) begin : g_chreg
    logic [WW-1:0] shd_q, act_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_q <= '0;
        act_q <= '0;
      end else begin
        if (wr_en && wr_addr == AW'(g)) shd_q <= wr_data;
        if (upd_all)                    act_q <= shd_q;
      end
    end
    assign act_div[g] = act_q[DW-1:0];
    assign act_ph[g]  = act_q[DW+PW-1:DW];
    assign act_ex[g]  = act_q[DW+PW];
  end

  logic [CW-1:0] ctl_shd_q, ctl_act_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_shd_q <= '0;
      ctl_act_q <= '0;
    end else begin
      if (wr_en && wr_addr == AW'(NCH)) ctl_shd_q <= wr_data[CW-1:0];
      if (upd_all)                      ctl_act_q <= ctl_shd_q;
    end
  end
  assign act_ctrl = ctl_act_q;
endmodule

// File: rtl/mcs_sync_ctrl.sv
module mcs_sync_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int REL_CNT     = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sync_n,
  input  logic                       pdn_n,
  input  logic                       cal_busy,
  input  logic [mcs_pkg::CTRL_W-1:0] soft_bits,
  output logic                       sync_req,
  output logic                       hold,
  output logic                       rel_pulse
);
  localparam int CW = $clog2(REL_CNT + 1);

  logic sync_n_s, pdn_n_s;
  logic [CW-1:0] rel_cnt_q;

  mcs_sync_ff #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pin (
    .clk(clk), .rst_n(rst_n), .d(sync_n), .q(sync_n_s));
  mcs_sync_ff #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pdn_pin (
    .clk(clk), .rst_n(rst_n), .d(pdn_n), .q(pdn_n_s));

  // every source folds into one request
  assign sync_req = !sync_n_s || !pdn_n_s || cal_busy || (|soft_bits);

  // quiet-cycle counter: restarts on any request, stops at REL_CNT;
  // reset value zero gives the power-up sync
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          rel_cnt_q <= '0;
    else if (sync_req)                   rel_cnt_q <= '0;
    else if (rel_cnt_q != CW'(REL_CNT))  rel_cnt_q <= rel_cnt_q + CW'(1);
  end

  assign hold      = sync_req || (rel_cnt_q != CW'(REL_CNT));
  assign rel_pulse = !sync_req && (rel_cnt_q == CW'(REL_CNT - 1));
endmodule

// File: rtl/mcs_chan_div.sv
module mcs_chan_div #(
  parameter int DW = 4,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic [DW-1:0] cfg_div,
  input  logic [PW-1:0] cfg_ph,
  output logic          run,
  output logic          out
);
  localparam int CW = DW + 1;

  logic [DW-1:0] div_q;
  logic [PW-1:0] wait_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_cnt, hi_cnt;

  assign last_cnt = CW'(mcs_pkg::div_ratio(32'(div_q)) - 1);
  assign hi_cnt   = CW'(mcs_pkg::high_len(32'(div_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      wait_q <= '0;
      cnt_q  <= '0;
    end else if (hold_i) begin
      div_q  <= cfg_div;
      wait_q <= cfg_ph;
      cnt_q  <= '0;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - PW'(1);
    end else begin
      cnt_q  <= (cnt_q == last_cnt) ? '0 : cnt_q + CW'(1);
    end
  end

  assign run = !hold_i && (wait_q == '0);
  assign out = run && (cnt_q < hi_cnt);
endmodule

// File: rtl/mcs_divsync.sv
module mcs_divsync #(
  parameter int NCH         = 4,
  parameter int DW          = 4,
  parameter int PW          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int REL_CNT     = 13,
  parameter int AW          = $clog2(NCH + 1),
  parameter int WW          = DW + PW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sync_n,
  input  logic           pdn_n,
  input  logic           cal_busy,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [WW-1:0]  wr_data,
  input  logic           upd_all,
  output logic [NCH-1:0] clk_out
);
  logic [NCH-1:0][DW-1:0]     act_div;
  logic [NCH-1:0][PW-1:0]     act_ph;
  logic [NCH-1:0]             excl_vec;
  logic [mcs_pkg::CTRL_W-1:0] act_ctrl;
  logic                       sync_req, hold, rel_pulse;
  logic [NCH-1:0]             chan_hold, run_vec;

  mcs_regfile #(.NCH(NCH), .DW(DW), .PW(PW), .AW(AW), .WW(WW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .upd_all(upd_all), .act_div(act_div),
    .act_ph(act_ph), .act_ex(excl_vec), .act_ctrl(act_ctrl));

  mcs_sync_ctrl #(.SYNC_STAGES(SYNC_STAGES), .REL_CNT(REL_CNT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .pdn_n(pdn_n),
    .cal_busy(cal_busy), .soft_bits(act_ctrl), .sync_req(sync_req),
    .hold(hold), .rel_pulse(rel_pulse));

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign chan_hold[g] = hold && !excl_vec[g];
    mcs_chan_div #(.DW(DW), .PW(PW)) u_div (
      .clk(clk), .rst_n(rst_n), .hold_i(chan_hold[g]),
      .cfg_div(act_div[g]), .cfg_ph(act_ph[g]),
      .run(run_vec[g]), .out(clk_out[g]));
  end
endmodule

// File: rtl/mcs_divsync_chk.sv
module mcs_divsync_chk #(
  parameter int NCH     = 4,
  parameter int REL_CNT = 13
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sync_req,
  input logic           hold,
  input logic           rel_pulse,
  input logic [NCH-1:0] excl,
  input logic [NCH-1:0] run,
  input logic [NCH-1:0] clk_out
);
  localparam int QW = $clog2(REL_CNT + 2);

  logic [QW-1:0] quiet_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          quiet_q <= '0;
    else if (sync_req)                   quiet_q <= '0;
    else if (quiet_q != QW'(REL_CNT + 1)) quiet_q <= quiet_q + QW'(1);
  end

  // R3
  hold_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |=> hold);

  // R4
  release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> (quiet_q == QW'(REL_CNT)));

  // R4
  release_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |=> !hold);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R3
    held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !excl[g]) |-> !clk_out[g]);

    // R6
    excl_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (excl[g] && $past(excl[g]) && $past(run[g])) |-> run[g]);
  end
endmodule

bind mcs_divsync mcs_divsync_chk #(.NCH(NCH), .REL_CNT(REL_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .hold(hold),
  .rel_pulse(rel_pulse), .excl(excl_vec), .run(run_vec), .clk_out(clk_out));

// File: tb/mcs_divsync_tb.sv
`timescale 1ns/1ps
module mcs_divsync_tb;
  localparam int NCH = 4, DW = 4, PW = 4;
  localparam int AW = $clog2(NCH + 1), WW = DW + PW + 1;
  localparam int LAT_PIN = 15, LAT_SOFT = 14, LAT_CAL = 13, LAT_PUP = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sync_n = 1'b1, pdn_n = 1'b1, cal_busy = 1'b0;
  logic wr_en = 1'b0, upd_all = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic [NCH-1:0] clk_out;

  always #2.5 clk = ~clk;

  mcs_divsync #(.NCH(NCH), .DW(DW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .pdn_n(pdn_n),
    .cal_busy(cal_busy), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .upd_all(upd_all), .clk_out(clk_out));

  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R10";
  bit [NCH-1:0] cmp_mask = '0;
  logic [NCH-1:0] prev_out = '0;
  int m_start[NCH], m_r[NCH], m_p[NCH], first_rise[NCH];
  int s_div[NCH], s_ph[NCH], a_div[NCH], a_ph[NCH];
  bit s_ex[NCH], a_ex[NCH];
  int s_ctrl = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // expected output of channel i after the edge that brought cyc to c
  function automatic int exp_out(int c, int i);
    int t = c - m_start[i] - m_p[i];
    if (t < 0) return 0;
    return ((t % m_r[i]) < (m_r[i] / 2)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    if (rst_n && !done) begin
      for (int i = 0; i < NCH; i++) begin
        if (cmp_mask[i])
          chk(clk_out[i] == exp_out(cyc, i)[0], a_ex[i] ? "R6" : cur_req,
              $sformatf("clk_out[%0d]", i), int'(clk_out[i]), exp_out(cyc, i));
        if (clk_out[i] && !prev_out[i] && first_rise[i] < 0) first_rise[i] = cyc;
      end
    end
    prev_out = clk_out;
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = WW'(d);
    if (a < NCH) begin
      s_div[a] = d % 16; s_ph[a] = (d / 16) % 16; s_ex[a] = ((d / 256) % 2) != 0;
    end else s_ctrl = d % 8;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_chan(int i, int dv, int ph, bit ex);
    wr(i, (int'(ex) << (DW + PW)) | (ph << DW) | dv);
  endtask

  task automatic copy_active();
    for (int i = 0; i < NCH; i++) begin
      a_div[i] = s_div[i]; a_ph[i] = s_ph[i]; a_ex[i] = s_ex[i];
    end
  endtask

  task automatic hold_begin();
    for (int i = 0; i < NCH; i++) cmp_mask[i] = a_ex[i];
  endtask

  task automatic apply_release(int start);
    for (int i = 0; i < NCH; i++) begin
      if (!a_ex[i]) begin
        m_start[i] = start; m_r[i] = a_div[i] + 2; m_p[i] = a_ph[i];
        first_rise[i] = -1;
      end
      cmp_mask[i] = 1'b1;
    end
  endtask

  task automatic check_low(string req);
    for (int i = 0; i < NCH; i++)
      if (!a_ex[i]) chk(clk_out[i] == 1'b0, req, $sformatf("held clk_out[%0d]", i), int'(clk_out[i]), 0);
  endtask

  task automatic check_rises(string req);
    for (int i = 0; i < NCH; i++)
      if (!a_ex[i]) chk(first_rise[i] == m_start[i] + m_p[i], req,
                        $sformatf("first rise ch%0d", i), first_rise[i], m_start[i] + m_p[i]);
  endtask

  task automatic strobe_plain();
    @(negedge clk); upd_all = 1'b1; copy_active();
    @(negedge clk); upd_all = 1'b0;
  endtask

  task automatic pin_event(bit use_pdn, int low);
    @(negedge clk); hold_begin();
    if (use_pdn) pdn_n = 1'b0; else sync_n = 1'b0;
    repeat (low) @(negedge clk);
    check_low(use_pdn ? "R8" : "R3");
    if (use_pdn) pdn_n = 1'b1; else sync_n = 1'b1;
    apply_release(cyc + LAT_PIN);
  endtask

  task automatic soft_event(int bitn, int len);
    wr(NCH, 1 << bitn);
    @(negedge clk); hold_begin(); upd_all = 1'b1; copy_active();
    @(negedge clk); upd_all = 1'b0;
    repeat (len) @(negedge clk);
    check_low("R7");
    wr(NCH, 0);
    @(negedge clk); upd_all = 1'b1; copy_active(); apply_release(cyc + LAT_SOFT);
    @(negedge clk); upd_all = 1'b0;
  endtask

  task automatic cal_event(int len);
    @(negedge clk); hold_begin(); cal_busy = 1'b1;
    repeat (len) @(negedge clk);
    check_low("R9");
    cal_busy = 1'b0;
    apply_release(cyc + LAT_CAL);
  endtask

  task automatic run_for(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd5113));
    for (int i = 0; i < NCH; i++) begin
      m_start[i] = 0; m_r[i] = 2; m_p[i] = 0; first_rise[i] = -1;
      s_div[i] = 0; s_ph[i] = 0; s_ex[i] = 0;
    end
    copy_active();

    // R10: reset state and power-up release with defaults
    repeat (3) @(posedge clk);
    #1 chk(clk_out == '0, "R10", "outputs in reset", int'(clk_out), 0);
    @(negedge clk); rst_n = 1'b1; cur_req = "R10";
    apply_release(cyc + LAT_PUP);
    run_for(24);
    check_rises("R10");

    // R11: updates while running leave the outputs alone
    cur_req = "R11";
    for (int i = 0; i < NCH; i++) wr_chan(i, 3, 2, 1'b0);
    strobe_plain();
    run_for(20);

    // R4 / R5: equal delays, pin sync
    cur_req = "R4";
    pin_event(1'b0, 4);
    run_for(40);
    check_rises("R4");
    for (int i = 1; i < NCH; i++)
      chk(first_rise[i] == first_rise[0], "R5", $sformatf("equal delay ch%0d", i), first_rise[i], first_rise[0]);

    // R5: spaced delays
    cur_req = "R5";
    wr_chan(0, 2, 0, 1'b0); wr_chan(1, 2, 1, 1'b0);
    wr_chan(2, 5, 3, 1'b0); wr_chan(3, 6, 7, 1'b0);
    strobe_plain();
    pin_event(1'b0, 5);
    run_for(40);
    check_rises("R5");
    for (int i = 1; i < NCH; i++)
      chk(first_rise[i] - first_rise[0] == a_ph[i], "R5", $sformatf("spacing ch%0d", i),
          first_rise[i] - first_rise[0], a_ph[i]);

    // R2: ratio extremes
    cur_req = "R2";
    wr_chan(0, 0, 0, 1'b0); wr_chan(1, 15, 15, 1'b0);
    wr_chan(2, 1, 0, 1'b0); wr_chan(3, 14, 5, 1'b0);
    strobe_plain();
    pin_event(1'b0, 3);
    run_for(60);
    check_rises("R2");

    // R6: excluded channels run through a pin sync and a calibration
    cur_req = "R3";
    wr_chan(0, 4, 2, 1'b0); wr_chan(1, 9, 6, 1'b1);
    wr_chan(2, 3, 0, 1'b0); wr_chan(3, 1, 3, 1'b1);
    strobe_plain();
    pin_event(1'b0, 8);
    run_for(40);
    check_rises("R3");
    cal_event(6);
    run_for(40);
    check_rises("R9");

    // R1: shadow write without strobe has no effect on the next release
    cur_req = "R1";
    wr_chan(0, 12, 9, 1'b0); wr_chan(2, 11, 4, 1'b1);
    pin_event(1'b0, 4);
    run_for(40);
    check_rises("R1");
    chk(m_r[0] == 6 && m_p[0] == 2, "R1", "ch0 settings unchanged", m_r[0], 6);

    // R7: each control bit
    wr_chan(0, 4, 1, 1'b0); wr_chan(1, 7, 0, 1'b0);
    wr_chan(2, 2, 5, 1'b0); wr_chan(3, 3, 2, 1'b1);
    strobe_plain();
    for (int b = 0; b < 3; b++) begin
      cur_req = "R7";
      soft_event(b, 4 + b);
      run_for(35);
      check_rises("R7");
    end

    // R8: power-down pin
    cur_req = "R8";
    pin_event(1'b1, 5);
    run_for(35);
    check_rises("R8");

    // R9: calibration
    cur_req = "R9";
    cal_event(9);
    run_for(35);
    check_rises("R9");

    // R12: overlapping calibration and pin request
    cur_req = "R12";
    @(negedge clk); hold_begin(); sync_n = 1'b0; cal_busy = 1'b1;
    repeat (4) @(negedge clk);
    cal_busy = 1'b0;
    repeat (20) @(negedge clk);
    check_low("R12");
    sync_n = 1'b1;
    apply_release(cyc + LAT_PIN);
    run_for(40);
    check_rises("R12");

    // constrained random rounds
    for (int r = 0; r < 14; r++) begin
      for (int i = 0; i < NCH; i++)
        wr_chan(i, $urandom_range(0, 15), $urandom_range(0, 15), ($urandom_range(0, 2) == 0));
      cur_req = "R11";
      strobe_plain();
      run_for($urandom_range(2, 12));
      case ($urandom_range(0, 5))
        0: begin cur_req = "R4"; pin_event(1'b0, $urandom_range(3, 9)); end
        1: begin cur_req = "R8"; pin_event(1'b1, $urandom_range(3, 9)); end
        2: begin cur_req = "R9"; cal_event($urandom_range(3, 9)); end
        default: begin cur_req = "R7"; soft_event($urandom_range(0, 2), $urandom_range(3, 9)); end
      endcase
      run_for(50);
      check_rises("R5");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule